// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch program counter and guesses where the next fetch should go. It keeps a table of two-bit saturating confidence counters for branch direction and a direct-mapped, tagged target buffer. Both tables are indexed by the low word-address bits of the program counter. The prediction is combinational. For the PC on `fetchPc`, the block drives a predicted-taken flag and a next PC in the same cycle. It redirects only when the target buffer hits and the counter leans toward taken. In every other case fetch continues at PC+4.

When a branch resolves in execute, the pipeline presents its PC, its actual direction and its actual target on the update port. In that same cycle the block compares that outcome against what it would predict for that PC from its current state. It raises `mispredict` so the pipeline can flush. At the next clock edge it trains the counter, and on a taken outcome it fills the target buffer entry. Instructions are 32 bits wide, so PC bits [1:0] are ignored.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and every target entry is invalid, so every fetch PC predicts not-taken with next PC = PC+4.
- R2: A taken update raises the counter by one step in the order 00, 01, 10, 11, and the counter stays at 11 once there.
- R3: A not-taken update lowers the counter by one step, and the counter stays at 00 once there.
- R4: `predTaken` is 1 and `predNextPc` equals the stored target exactly when the target entry hits and the counter's upper bit is 1 (codes 10 and 11).
- R5: On a miss, or when the counter is 00 or 01, `predTaken` is 0 and `predNextPc` is `fetchPc`+4.
- R6: The index is PC bits [IDX_W+1:2] and the tag is the PC bits above those. A hit needs a valid entry whose tag matches, so two PCs that share an index but differ in upper bits do not hit each other's entry.
- R7: A taken update writes the entry's valid bit, tag and target. A not-taken update changes only the counter and leaves the stored target in place.
- R8: With `updValid` high, `mispredict` is 1 in the same cycle when the predicted direction for `updPc` differs from `updTaken`, or when both are taken and the stored target differs from `updTarget`. With `updValid` low, `mispredict` is 0.
- R9: An update takes effect at the clock edge that ends its cycle, so a lookup of the same entry in that cycle still sees the old state.
- R10: A loop branch taken 99 times and then not taken, once trained, mispredicts only at the exit, and the first iteration of the next pass is predicted taken without a mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchPc | input | PC_W | Current fetch program counter |
| predTaken | output | 1 | Predicted taken for fetchPc |
| predNextPc | output | PC_W | Predicted next fetch PC |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Actual direction of the resolved branch |
| updTarget | input | PC_W | Actual target of the resolved branch |
| mispredict | output | 1 | Resolved outcome disagrees with the prediction |

## Verification
Both the prediction and `mispredict` are combinational. The bench therefore samples `mispredict` a few nanoseconds after it drives the update at the falling edge, before the rising edge that commits the training. The trained state only shows up after that rising edge, so predictions for a given fetch PC are read five nanoseconds after it. In the same-cycle case the prediction is also read before the edge, where it must still reflect the old state.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Two-bit direction counter codes
  localparam logic [1:0] CNT_SNT = 2'b00;
  localparam logic [1:0] CNT_WNT = 2'b01;
  localparam logic [1:0] CNT_WT  = 2'b10;
  localparam logic [1:0] CNT_ST  = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic       cntWe;
    logic [1:0] cntVal;
    logic       btbWe;
  } bpStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == CNT_ST)  ? CNT_ST  : cur + 2'd1;
    else    nxt = (cur == CNT_SNT) ? CNT_SNT : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  bpStrobe_t       strobe,
  output logic [1:0]      updCnt,
  output logic            updHit,
  output logic [PC_W-1:0] updStoredTarget
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam int TAG_LO  = IDX_W + 2;

  logic [ENTRIES-1:0][1:0]      cntArr;
  logic [ENTRIES-1:0]           validVec;
  logic [ENTRIES-1:0][TAG_W-1:0] tagArr;
  logic [ENTRIES-1:0][PC_W-1:0] tgtArr;

  logic [IDX_W-1:0] fetchIdx, updIdx;
  logic [TAG_W-1:0] fetchTag, updTag;
  logic             fetchHit;

  assign fetchIdx = fetchPc[TAG_LO-1:2];
  assign fetchTag = fetchPc[PC_W-1:TAG_LO];
  assign updIdx   = updPc[TAG_LO-1:2];
  assign updTag   = updPc[PC_W-1:TAG_LO];

  // Per-entry storage
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntArr[e]   <= CNT_WNT;
        validVec[e] <= 1'b0;
        tagArr[e]   <= '0;
        tgtArr[e]   <= '0;
      end else begin
        if (strobe.cntWe && updIdx == IDX_W'(e)) cntArr[e] <= strobe.cntVal;
        if (strobe.btbWe && updIdx == IDX_W'(e)) begin
          validVec[e] <= 1'b1;
          tagArr[e]   <= updTag;
          tgtArr[e]   <= updTarget;
        end
      end
    end
  end

  // Fetch-side lookup
  assign fetchHit   = validVec[fetchIdx] && (tagArr[fetchIdx] == fetchTag);
  assign predTaken  = fetchHit && cntArr[fetchIdx][1];
  assign predNextPc = predTaken ? tgtArr[fetchIdx] : fetchPc + PC_W'(4);

  // Update-side lookup
  assign updCnt          = cntArr[updIdx];
  assign updHit          = validVec[updIdx] && (tagArr[updIdx] == updTag);
  assign updStoredTarget = tgtArr[updIdx];

  // R9: without an update the tables hold still
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(cntArr) && $stable(validVec));

  // R7: a BTB write leaves the entry valid
  p_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.btbWe |=> validVec[$past(updIdx)]);

  // R5: without a redirect fetch falls through
  p_fallthrough_r5: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4));

endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            updValid,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  input  logic [1:0]      updCnt,
  input  logic            updHit,
  input  logic [PC_W-1:0] updStoredTarget,
  output bpStrobe_t       strobe,
  output logic            mispredict
);
  logic predDir;
  logic dirWrong;
  logic tgtWrong;

  assign predDir  = updHit && updCnt[1];
  assign dirWrong = predDir != updTaken;
  assign tgtWrong = predDir && updTaken && (updStoredTarget != updTarget);

  always_comb begin
    strobe        = '0;
    strobe.cntWe  = updValid;
    strobe.cntVal = satStep(updCnt, updTaken);
    strobe.btbWe  = updValid && updTaken;
  end

  assign mispredict = updValid && (dirWrong || tgtWrong);

  // R2: taken training never lowers the counter
  p_inc_mono_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken) |-> strobe.cntVal >= updCnt);

  // R3: not-taken training never raises the counter
  p_dec_mono_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken) |-> strobe.cntVal <= updCnt);

  // R8: no flush request without an update
  p_mis_needs_upd_r8: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> updValid);

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  output logic            mispredict
);
  bpStrobe_t       strobe;
  logic [1:0]      updCnt;
  logic            updHit;
  logic [PC_W-1:0] updStoredTarget;

  bp_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .fetchPc(fetchPc), .predTaken(predTaken), .predNextPc(predNextPc),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget),
    .strobe(strobe), .updCnt(updCnt), .updHit(updHit),
    .updStoredTarget(updStoredTarget)
  );

  bp_control #(.PC_W(PC_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .updValid(updValid), .updTaken(updTaken), .updTarget(updTarget),
    .updCnt(updCnt), .updHit(updHit), .updStoredTarget(updStoredTarget),
    .strobe(strobe), .mispredict(mispredict)
  );

endmodule

// File: tb/branch_predictor_test.sv
module branch_predictor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predTaken;
  logic [31:0] predNextPc;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic        mispredict;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  branch_predictor uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .predNextPc(predNextPc), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updTarget(updTarget), .mispredict(mispredict)
  );

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utg;
    logic [31:0] fpc;
    logic        expMis;
    logic        expTaken;
    logic [31:0] expNext;
  } vec_t;

  // Index bits [5:2], tag bits [31:6]
  localparam vec_t VECS [16] = '{
    '{1'b1, 32'h100, 1'b1, 32'h080, 32'h100, 1'b1, 1'b1, 32'h080}, // R8 miss, R2 01->10
    '{1'b1, 32'h100, 1'b1, 32'h080, 32'h100, 1'b0, 1'b1, 32'h080}, // R2 10->11
    '{1'b1, 32'h100, 1'b1, 32'h080, 32'h100, 1'b0, 1'b1, 32'h080}, // R2 saturate 11
    '{1'b1, 32'h100, 1'b0, 32'h000, 32'h100, 1'b1, 1'b1, 32'h080}, // R3 11->10
    '{1'b1, 32'h100, 1'b0, 32'h000, 32'h100, 1'b1, 1'b0, 32'h104}, // R3 10->01, R5
    '{1'b1, 32'h100, 1'b0, 32'h000, 32'h100, 1'b0, 1'b0, 32'h104}, // R3 01->00
    '{1'b1, 32'h100, 1'b0, 32'h000, 32'h100, 1'b0, 1'b0, 32'h104}, // R3 saturate 00
    '{1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b0, 32'h104}, // R2 00->01
    '{1'b1, 32'h100, 1'b1, 32'h200, 32'h100, 1'b1, 1'b1, 32'h200}, // R4 01->10
    '{1'b0, 32'h000, 1'b0, 32'h000, 32'h140, 1'b0, 1'b0, 32'h144}, // R6 alias misses
    '{1'b1, 32'h100, 1'b1, 32'h300, 32'h100, 1'b1, 1'b1, 32'h300}, // R8 wrong target
    '{1'b1, 32'h104, 1'b0, 32'h000, 32'h100, 1'b0, 1'b1, 32'h300}, // R6 other index
    '{1'b1, 32'h140, 1'b1, 32'h400, 32'h100, 1'b1, 1'b0, 32'h104}, // R6 alias evicts
    '{1'b1, 32'h108, 1'b1, 32'h500, 32'h108, 1'b1, 1'b1, 32'h500}, // R7 fill
    '{1'b1, 32'h108, 1'b1, 32'h500, 32'h108, 1'b0, 1'b1, 32'h500}, // R4
    '{1'b1, 32'h108, 1'b0, 32'h000, 32'h108, 1'b1, 1'b1, 32'h500}  // R7 target kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One update cycle; returns mispredict seen before the edge
  task automatic doUpdate(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                          output logic mis);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = tk; updTarget = tg;
    #5 mis = mispredict;
    @(posedge clk);
    #5 updValid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    logic mis;
    int   misTaken;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fetchPc = 32'h1000 + 32'(k * 4);
      #5;
      chk("R1 predTaken", {31'b0, predTaken}, 32'd0);
      chk("R1 predNextPc", predNextPc, fetchPc + 32'd4);
      chk("R8 idle mispredict", {31'b0, mispredict}, 32'd0);
    end

    // Vector table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      updValid = VECS[i].uv; updPc = VECS[i].upc; updTaken = VECS[i].ut;
      updTarget = VECS[i].utg; fetchPc = VECS[i].fpc;
      #5 chk($sformatf("R8 mispredict vec%0d", i), {31'b0, mispredict}, {31'b0, VECS[i].expMis});
      @(posedge clk);
      #5;
      chk($sformatf("R4 predTaken vec%0d", i), {31'b0, predTaken}, {31'b0, VECS[i].expTaken});
      chk($sformatf("R5 predNextPc vec%0d", i), predNextPc, VECS[i].expNext);
      updValid = 1'b0;
    end

    // R9: same-cycle update not visible until next edge
    @(negedge clk);
    fetchPc = 32'h10C;
    updValid = 1'b1; updPc = 32'h10C; updTaken = 1'b1; updTarget = 32'h600;
    #5;
    chk("R9 same-cycle predTaken", {31'b0, predTaken}, 32'd0);
    chk("R9 same-cycle predNextPc", predNextPc, 32'h110);
    @(posedge clk);
    #5 updValid = 1'b0;
    chk("R9 next-cycle predTaken", {31'b0, predTaken}, 32'd1);
    chk("R9 next-cycle predNextPc", predNextPc, 32'h600);

    // R10: loop branch at 0x110, passes of 99 taken + 1 exit
    for (int pass = 0; pass < 3; pass++) begin
      misTaken = 0;
      for (int it = 0; it < 99; it++) begin
        doUpdate(32'h110, 1'b1, 32'h020, mis);
        if (mis) misTaken++;
        if (pass > 0 && it == 0)
          chk("R10 re-entry no mispredict", {31'b0, mis}, 32'd0);
      end
      doUpdate(32'h110, 1'b0, 32'h000, mis);
      if (pass > 0) begin
        chk("R10 taken iterations mispredicts", 32'(misTaken), 32'd0);
        chk("R10 exit mispredict", {31'b0, mis}, 32'd1);
      end
      @(negedge clk);
      fetchPc = 32'h110;
      #5;
      chk("R10 predicted taken after exit", {31'b0, predTaken}, 32'd1);
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule